// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

The block collects interrupt events from on-chip sources and stores each one as a four-word vector in a circular buffer in memory. Each vector is 16 bytes, and the ring size is a power of two. Memory is reached through a plain single-port write interface, one 32-bit word per cycle. Incoming events first wait in a small queue with a valid/ready handshake. A vector is written only while both the ring-enable and interrupt-enable bits are set.

Software programs the block through a small register write port. Through that port it sets the ring base, the ring size and a writeback location. It also returns the consumer's read position by writing the read pointer. The block keeps a byte-offset write pointer and exposes it, together with a sticky overflow flag in bit 0, as a single status word. When writeback is on, the block mirrors that word to memory after every vector. An interrupt line stays high while unread vectors remain or an overflow has not been acknowledged.

When a vector fills the last free slot, the write pointer laps onto the read pointer. The vector is still written and the overflow flag is raised. The ring therefore always keeps the newest vectors, and software resumes reading one slot past the reported write pointer.

Top module: `irq_ring_writer`

## Requirements
- R1: Each vector is written as four words, one per cycle, in ascending order, at byte addresses ringBase + wptr + 0, 4, 8, 12. The word contents are: word 0 = {24'b0, evtSrc}, word 1 = {4'b0, evtData}, word 2 = evtCtx, word 3 = 0. No write goes outside the ring and the writeback location.
- R2: After each vector, the write pointer advances by 16 bytes. It wraps to zero at the ring size in bytes, which is 4 << size, where size is control bits [6:2] (log2 of the ring size in 32-bit words). wptrWord reports the pointer in its low bits.
- R3: irqOut is high exactly when control bit 0 (ring enable) and bit 1 (interrupt enable) are both set and either the read pointer differs from the write pointer or the overflow flag is set.
- R4: When a vector is written and the advanced write pointer equals the read pointer, bit 0 of wptrWord (the overflow flag) becomes 1. The flag stays set across later vectors. The vector is still stored and the pointer still advances.
- R5: A control write with bit 7 set clears the overflow flag. Bit 7 is not stored, so the other control fields take the written values.
- R6: No vector is written unless ring enable and interrupt enable are both set. Events arriving meanwhile remain queued and are written once both bits are set.
- R7: With control bit 8 (writeback enable) set, each vector is followed by exactly one extra write of wptrWord, including the overflow bit, to the writeback address. With bit 8 clear, no such write occurs.
- R8: The input queue holds QUEUE_DEPTH events. evtReady is low while it is full, and vectors are written in arrival order.
- R9: A write to register 3 sets the write pointer to zero while ring enable is clear and has no effect while it is set. A write to register 2 loads the read pointer with the written value masked to the ring size and to 16-byte steps.
- R10: Register select values are: 0 control, 1 ring base address bits 39:8, 2 read pointer, 3 write-pointer clear, 4 writeback address bits 39:8.
- R11: After reset, wptrWord is 0, irqOut is 0, memWrEn is 0 and evtReady is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event offered |
| evtReady | output | 1 | Queue can accept an event |
| evtSrc | input | 8 | Source identifier of the event |
| evtData | input | 28 | Source-specific payload |
| evtCtx | input | 32 | Context word stored in vector word 2 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 40 | Memory byte address |
| memWrData | output | 32 | Memory write data |
| wptrWord | output | 32 | Write pointer in bytes, overflow flag in bit 0 |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the block with MAX_LOG2_WORDS = 6 and QUEUE_DEPTH = 2 and programs a ring size of 16 words, which gives four vector slots. With four slots, the pointer wrap and the lap onto an unread position both occur within a handful of vectors. With a two-entry queue, two events pushed while the ring is disabled are enough to drop evtReady and to check the order in which held events are written. Read-pointer writes with out-of-range values exercise the size mask on the same small ring.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int unsigned ADDR_W    = 40;
  localparam int unsigned VEC_BYTES = 16;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_BASE   = 3'd1;
  localparam logic [2:0] REG_RPTR   = 3'd2;
  localparam logic [2:0] REG_WPTR   = 3'd3;
  localparam logic [2:0] REG_WBADDR = 3'd4;

  localparam int unsigned CTRL_RING_EN = 0;
  localparam int unsigned CTRL_INT_EN  = 1;
  localparam int unsigned CTRL_SIZE_LO = 2;
  localparam int unsigned CTRL_SIZE_W  = 5;
  localparam int unsigned CTRL_OVF_CLR = 7;
  localparam int unsigned CTRL_WB_EN   = 8;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       wrWord;
    logic [1:0] wordIdx;
    logic       advance;
    logic       wbWrite;
  } wrStrobe_t;

  typedef struct packed {
    logic [7:0]  src;
    logic [27:0] data;
    logic [31:0] ctx;
  } irqEvent_t;
endpackage

// File: rtl/irw_evq.sv
module irw_evq #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 68
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  input  logic             pop
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign inReady  = (count != FULL_CNT);
  assign outValid = (count != '0);
  assign doPush   = inValid && inReady;
  assign doPop    = pop && outValid;
  assign outData  = slots[headIdx];

  always_ff @(posedge clk) begin
    if (doPush) slots[tailIdx] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
    end else begin
      if (doPush) tailIdx <= (tailIdx == LAST_IDX) ? '0 : tailIdx + 1'b1;
      if (doPop)  headIdx <= (headIdx == LAST_IDX) ? '0 : headIdx + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_CNT && !pop) |=> (count == FULL_CNT));
  a_r8_no_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> outValid);
endmodule

// File: rtl/irw_ctrl.sv
module irw_ctrl
  import irw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      qValid,
  input  logic      ringActive,
  input  logic      wbEn,
  output wrStrobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_WORD, ST_WB} seqState_e;

  seqState_e  state;
  logic [1:0] wordIdx;

  always_comb begin
    strb = '0;
    case (state)
      ST_WORD: begin
        strb.wrWord  = 1'b1;
        strb.wordIdx = wordIdx;
        strb.advance = (wordIdx == 2'd3);
      end
      ST_WB:   strb.wbWrite = 1'b1;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          wordIdx <= '0;
          if (qValid && ringActive) state <= ST_WORD;
        end
        ST_WORD: begin
          wordIdx <= wordIdx + 1'b1;
          if (wordIdx == 2'd3) state <= wbEn ? ST_WB : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_wb_after_vector: assert property (@(posedge clk) disable iff (!rstN)
    strb.wbWrite |-> $past(strb.advance));
  a_r1_word_sequence: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrWord && strb.wordIdx != 2'd0) |->
      ($past(strb.wrWord) && ($past(strb.wordIdx) + 2'd1 == strb.wordIdx)));
endmodule

// File: rtl/irw_dpath.sv
module irw_dpath
  import irw_pkg::*;
#(
  parameter int unsigned MAX_LOG2_WORDS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  wrStrobe_t         strb,
  input  irqEvent_t         evt,
  output logic              ringActive,
  output logic              wbEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [31:0]       wptrWord,
  output logic              irq
);
  localparam int unsigned PTR_W   = MAX_LOG2_WORDS + 2;
  localparam logic [4:0]  SIZE_MIN = 5'd2;
  localparam logic [4:0]  SIZE_MAX = 5'(MAX_LOG2_WORDS);

  logic             ctrlRing, ctrlInt, ctrlWb;
  logic [4:0]       ctrlSize, sizeEff;
  logic [31:0]      baseHi, wbHi;
  logic [PTR_W-1:0] wptr, rptr, wptrNext, ptrMask, ringOff;
  logic [PTR_W:0]   span;
  logic             ovf, ctrlWr, ovfHit;

  always_comb begin
    if (ctrlSize < SIZE_MIN)      sizeEff = SIZE_MIN;
    else if (ctrlSize > SIZE_MAX) sizeEff = SIZE_MAX;
    else                          sizeEff = ctrlSize;
    span    = (PTR_W + 1)'(1) << (sizeEff + 5'd2);
    ptrMask = span[PTR_W-1:0] - 1'b1;
    ptrMask[3:0] = 4'h0;
  end

  assign wptrNext   = (wptr + PTR_W'(VEC_BYTES)) & ptrMask;
  assign ovfHit     = strb.advance && (wptrNext == rptr);
  assign ctrlWr     = regWrEn && (regAddr == REG_CTRL);
  assign ringActive = ctrlRing && ctrlInt;
  assign wbEn       = ctrlWb;
  assign wptrWord   = 32'(wptr) | {31'b0, ovf};
  assign irq        = ringActive && ((wptr != rptr) || ovf);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlRing <= 1'b0;
      ctrlInt  <= 1'b0;
      ctrlWb   <= 1'b0;
      ctrlSize <= '0;
      baseHi   <= '0;
      wbHi     <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_CTRL: begin
          ctrlRing <= regWrData[CTRL_RING_EN];
          ctrlInt  <= regWrData[CTRL_INT_EN];
          ctrlWb   <= regWrData[CTRL_WB_EN];
          ctrlSize <= regWrData[CTRL_SIZE_LO +: CTRL_SIZE_W];
        end
        REG_BASE:   baseHi <= regWrData;
        REG_WBADDR: wbHi   <= regWrData;
        default: ;
      endcase
    end
  end

  // pointers and overflow flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wptr <= '0;
      rptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (strb.advance)
        wptr <= wptrNext;
      else if (regWrEn && regAddr == REG_WPTR && !ctrlRing)
        wptr <= '0;
      if (regWrEn && regAddr == REG_RPTR)
        rptr <= regWrData[PTR_W-1:0] & ptrMask;
      if (ovfHit)
        ovf <= 1'b1;
      else if (ctrlWr && regWrData[CTRL_OVF_CLR])
        ovf <= 1'b0;
    end
  end

  // memory write port
  assign ringOff = wptr + PTR_W'({strb.wordIdx, 2'b00});

  always_comb begin
    memWrEn   = strb.wrWord || strb.wbWrite;
    memWrAddr = '0;
    memWrData = '0;
    if (strb.wrWord) begin
      memWrAddr = {baseHi, 8'h00} + ADDR_W'(ringOff);
      case (strb.wordIdx)
        2'd0:    memWrData = {24'b0, evt.src};
        2'd1:    memWrData = {4'b0, evt.data};
        2'd2:    memWrData = evt.ctx;
        default: memWrData = 32'h0;
      endcase
    end else if (strb.wbWrite) begin
      memWrAddr = {wbHi, 8'h00};
      memWrData = wptrWord;
    end
  end

  a_r6_start_needs_enables: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrWord && strb.wordIdx == 2'd0) |-> $past(ringActive));
  a_r2_wptr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    wptr[3:0] == 4'h0);
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !(ctrlWr && regWrData[CTRL_OVF_CLR])) |=> ovf);
  a_r9_wptr_hold_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_WPTR && ctrlRing && !strb.advance) |=> $stable(wptr));
endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
  import irw_pkg::*;
#(
  parameter int unsigned MAX_LOG2_WORDS = 12,
  parameter int unsigned QUEUE_DEPTH    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  output logic        evtReady,
  input  logic [7:0]  evtSrc,
  input  logic [27:0] evtData,
  input  logic [31:0] evtCtx,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic        memWrEn,
  output logic [39:0] memWrAddr,
  output logic [31:0] memWrData,
  output logic [31:0] wptrWord,
  output logic        irqOut
);
  localparam int unsigned EVT_W = $bits(irqEvent_t);

  irqEvent_t inEvt, headEvt;
  wrStrobe_t strb;
  logic      qValid, ringActive, wbEn;

  assign inEvt = '{src: evtSrc, data: evtData, ctx: evtCtx};

  irw_evq #(.DEPTH(QUEUE_DEPTH), .WIDTH(EVT_W)) evq_i (
    .clk(clk), .rstN(rstN),
    .inValid(evtValid), .inReady(evtReady), .inData(inEvt),
    .outValid(qValid), .outData(headEvt), .pop(strb.advance)
  );

  irw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .qValid(qValid),
    .ringActive(ringActive), .wbEn(wbEn), .strb(strb)
  );

  irw_dpath #(.MAX_LOG2_WORDS(MAX_LOG2_WORDS)) dpath_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strb(strb), .evt(headEvt),
    .ringActive(ringActive), .wbEn(wbEn),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .wptrWord(wptrWord), .irq(irqOut)
  );
endmodule

// File: tb/irq_ring_writer_tb_top.sv
module irq_ring_writer_tb_top;
  localparam int MAXL = 6;
  localparam int QD   = 2;
  localparam logic [39:0] RING_BASE = 40'h1200;
  localparam logic [39:0] WB_ADDR   = 40'h4000;
  localparam int RING_BYTES = 64;  // size field 4 -> 16 words

  // {src, data, ctx, consumeAfter}
  localparam logic [68:0] STIM [0:4] = '{
    {8'h31, 28'h0000101, 32'hA0000001, 1'b0},
    {8'h32, 28'h0000202, 32'hA0000002, 1'b1},
    {8'h33, 28'h0000303, 32'hA0000003, 1'b1},
    {8'h34, 28'h0000404, 32'hA0000004, 1'b1},
    {8'h35, 28'h0000505, 32'hA0000005, 1'b1}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, evtValid, evtReady, regWrEn, memWrEn, irqOut;
  logic [7:0]  evtSrc;
  logic [27:0] evtData;
  logic [31:0] evtCtx, regWrData, memWrData, wptrWord;
  logic [2:0]  regAddr;
  logic [39:0] memWrAddr;

  irq_ring_writer #(.MAX_LOG2_WORDS(MAXL), .QUEUE_DEPTH(QD)) dut_i (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
    .evtSrc(evtSrc), .evtData(evtData), .evtCtx(evtCtx),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .wptrWord(wptrWord), .irqOut(irqOut)
  );

  int checks = 0, errors = 0;
  int writeCount = 0, wbCount = 0, strayCount = 0;
  logic [31:0] ringMem [0:63];
  logic [31:0] wbVal = '0;
  int expWptr = 0, expRptr = 0;
  bit expOvf = 0;

  always @(posedge clk) begin
    if (rstN && memWrEn) begin
      writeCount++;
      if (memWrAddr >= RING_BASE && memWrAddr < RING_BASE + 40'd256)
        ringMem[int'((memWrAddr - RING_BASE) >> 2)] = memWrData;
      else if (memWrAddr == WB_ADDR) begin
        wbVal = memWrData;
        wbCount++;
      end else strayCount++;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pushEvt(logic [7:0] s, logic [27:0] d, logic [31:0] c);
    @(negedge clk);
    evtValid = 1'b1; evtSrc = s; evtData = d; evtCtx = c;
    for (int i = 0; i < 100; i++) begin
      if (evtReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic waitWrites(int base, int n);
    for (int i = 0; i < 60 && writeCount < base + n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkSlot(string tag, int off, logic [7:0] s, logic [27:0] d, logic [31:0] c);
    check({tag, " word0"}, ringMem[off/4],     {24'b0, s});
    check({tag, " word1"}, ringMem[off/4 + 1], {4'b0, d});
    check({tag, " word2"}, ringMem[off/4 + 2], c);
    check({tag, " word3"}, ringMem[off/4 + 3], 32'h0);
  endtask

  task automatic advanceModel();
    int nxt;
    nxt = (expWptr + 16) % RING_BYTES;
    if (nxt == expRptr) expOvf = 1'b1;
    expWptr = nxt;
  endtask

  task automatic runVec(logic [7:0] s, logic [27:0] d, logic [31:0] c, bit wb);
    int st, off;
    st = writeCount;
    off = expWptr;
    pushEvt(s, d, c);
    waitWrites(st, wb ? 5 : 4);
    checkSlot("R1 vector", off, s, d, c);
    advanceModel();
    check("R2/R4 wptr word", wptrWord, 32'(expWptr) | {31'b0, expOvf});
    if (wb) check("R7 writeback value", wbVal, 32'(expWptr) | {31'b0, expOvf});
    else begin
      repeat (6) @(negedge clk);
      check("R7 no writeback writes", 32'(writeCount - st), 32'd4);
    end
    check("R3 irq pending", {31'b0, irqOut}, 32'd1);
  endtask

  initial begin
    rstN = 1'b0; evtValid = 1'b0; evtSrc = '0; evtData = '0; evtCtx = '0;
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 wptrWord", wptrWord, 32'h0);
    check("R11 irqOut", {31'b0, irqOut}, 32'h0);
    check("R11 memWrEn", {31'b0, memWrEn}, 32'h0);
    check("R11 evtReady", {31'b0, evtReady}, 32'h1);

    // R10 register map: base, writeback, ring enable only
    regWrite(3'd1, 32'h12);
    regWrite(3'd4, 32'h40);
    regWrite(3'd0, 32'h011);
    begin
      int st;
      st = writeCount;
      pushEvt(8'h21, 28'h0AAAAAA, 32'hC0DE0001);
      repeat (20) @(negedge clk);
      check("R6 no write with interrupt enable clear", 32'(writeCount - st), 32'd0);
      check("R3 irq low while disabled", {31'b0, irqOut}, 32'd0);
      pushEvt(8'h22, 28'h0BBBBBB, 32'hC0DE0002);
      check("R8 evtReady low when full", {31'b0, evtReady}, 32'd0);
      regWrite(3'd0, 32'h113);
      waitWrites(st, 10);
      checkSlot("R8 first queued", 0, 8'h21, 28'h0AAAAAA, 32'hC0DE0001);
      checkSlot("R8 second queued", 16, 8'h22, 28'h0BBBBBB, 32'hC0DE0002);
      check("R2 wptr after two", wptrWord, 32'd32);
      check("R7 writeback", wbVal, 32'd32);
      check("R7 writeback count", 32'(wbCount), 32'd2);
      check("R3 irq pending", {31'b0, irqOut}, 32'd1);
      check("R8 evtReady back", {31'b0, evtReady}, 32'd1);
      expWptr = 32; expRptr = 0; expOvf = 1'b0;
    end

    // table walk: wrap, overflow, sticky flag
    for (int i = 0; i < 5; i++) begin
      runVec(STIM[i][68:61], STIM[i][60:33], STIM[i][32:1], 1'b1);
      if (STIM[i][0]) begin
        regWrite(3'd2, 32'(expWptr));
        expRptr = expWptr;
        @(negedge clk);
        check("R3/R4 irq after consume", {31'b0, irqOut},
              {31'b0, (expWptr != expRptr) || expOvf});
      end
    end
    check("R4 overflow flagged", {31'b0, wptrWord[0]}, 32'd1);

    // R5 clear overflow
    regWrite(3'd0, 32'h193);
    @(negedge clk);
    expOvf = 1'b0;
    check("R5 overflow cleared", wptrWord, 32'(expWptr));
    check("R3 irq idle", {31'b0, irqOut}, 32'd0);

    // R7 writeback off
    regWrite(3'd0, 32'h013);
    runVec(8'h41, 28'h0001111, 32'hB0000001, 1'b0);
    runVec(8'h42, 28'h0002222, 32'hB0000002, 1'b0);

    // R9 write pointer clear
    regWrite(3'd3, 32'h0);
    @(negedge clk);
    check("R9 wptr clear ignored while enabled", wptrWord, 32'(expWptr));
    regWrite(3'd0, 32'h012);
    @(negedge clk);
    check("R3 irq needs ring enable", {31'b0, irqOut}, 32'd0);
    regWrite(3'd3, 32'h0);
    regWrite(3'd2, 32'h0);
    @(negedge clk);
    check("R9 wptr cleared while disabled", wptrWord, 32'h0);
    expWptr = 0; expRptr = 0;

    // R6 interrupt enable without ring enable
    begin
      int st;
      st = writeCount;
      pushEvt(8'h51, 28'h0005555, 32'hD0000001);
      repeat (20) @(negedge clk);
      check("R6 no write with ring enable clear", 32'(writeCount - st), 32'd0);
      regWrite(3'd0, 32'h013);
      waitWrites(st, 4);
      checkSlot("R6 held event written", 0, 8'h51, 28'h0005555, 32'hD0000001);
      check("R2 wptr after restart", wptrWord, 32'd16);
    end

    // R9 read pointer masking: 0x50 -> 0x10 on a 64-byte ring
    regWrite(3'd2, 32'h50);
    @(negedge clk);
    check("R9 rptr masked to ring", {31'b0, irqOut}, 32'd0);
    check("R1 no stray writes", 32'(strayCount), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule